// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller for a configurable number of banks, each holding 32 pins. A single-cycle register port (address, write enable, write data, combinational read data) reaches one register window per bank, and the windows repeat every 0x200 bytes. Pin p lives in bank p / 32 at bit p mod 32. For each pin, software can read the synchronised input level, drive an output value with its own output enable, and choose a pull resistor (off, up or down) that the pad logic outside applies.

Every pin can also raise an interrupt. Three configuration bits pick the trigger: a type bit selects level or edge, a both-edges bit makes an edge pin fire on either transition, and a polarity bit selects rising/high or falling/low. Detected events are latched in a raw status register and cleared by writing ones to a clear register. A per-pin enable mask gates the raw status into a masked status, and one interrupt output is the OR of every masked status bit across all banks.

Pin inputs pass through a two-flop synchroniser before they are read or examined for edges. A handler is expected to clear a status bit before servicing it, so that an event arriving after the clear is caught again.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: A byte address selects bank `addr[ADDR_W-1:9]` and register offset `addr[8:0]`. Pin p maps to bit p mod 32 of bank p / 32. Offsets: 0x00 input level (read-only), 0x04 output value, 0x08 output enable, 0x0C trigger type, 0x10 both-edges enable, 0x14 polarity, 0x18 interrupt enable mask, 0x1C raw status (read-only), 0x20 masked status (read-only), 0x24 status clear (write-only, reads 0), 0x34 pull direction, 0x38 pull enable.
- R2: A read of offset 0x00 returns the pin inputs after a two-flop synchroniser: the value is the one present on `pin_in` two rising clock edges earlier.
- R3: `pin_out` and `pin_oe` show the output value and output enable registers, updated on the edge of the write. An enable bit of 1 makes the pin an output; 0 makes it an input.
- R4: `pull_en` and `pull_up` show the pull enable (offset 0x38) and pull direction (offset 0x34) registers. Enable 0 means no pull; with enable 1, direction 1 is pull-up and 0 is pull-down.
- R5: A trigger type bit of 1 makes the pin level-triggered: its raw status bit is set on every clock in which the synchronised input equals the polarity bit, including the clock of a clear, so it re-asserts while the active level persists.
- R6: A trigger type bit of 0 makes the pin edge-triggered. With the both-edges bit 0, polarity 1 detects a rising edge and polarity 0 a falling edge of the synchronised input. The raw status bit then stays set until cleared.
- R7: With trigger type 0 and both-edges bit 1, either edge sets the raw status bit whatever the polarity bit holds.
- R8: The masked status (offset 0x20) reads raw status AND the enable mask; a mask bit of 0 keeps that pin out of the interrupt.
- R9: Writing 1 to a bit of offset 0x24 clears that raw status bit on the write's clock edge; writing 0 leaves it unchanged. An event detected in the same clock as the clear leaves the bit set.
- R10: `irq` is high exactly when any masked status bit in any bank is set.
- R11: Reset clears every register. Reads of unused offsets return 0, and writes to unused or read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address (bank and offset) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pin_in | input | NUM_BANKS*32 | Raw pin input levels |
| pin_out | output | NUM_BANKS*32 | Output value per pin |
| pin_oe | output | NUM_BANKS*32 | Output enable per pin |
| pull_en | output | NUM_BANKS*32 | Pull resistor enable per pin |
| pull_up | output | NUM_BANKS*32 | Pull direction per pin (1 up, 0 down) |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong synchroniser or edge history shows as an input read that is off by a cycle, or as a raw status bit set without a matching transition, visible at the status read and at `irq` within one clock of the faulty detection. A corrupted configuration or status register shows on the pin outputs or `irq` on the very next cycle, since the bench compares those ports against a behavioural model every clock. Clear and level-reassertion ordering errors show as a status bit that reads 0 after a clear while the active level persists, or stays 1 after a clear with no event.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PINS_PER_BANK = 32;
    localparam int OFF_W         = 9;

    localparam logic [OFF_W-1:0] OFF_LEVEL_IN = 9'h000;
    localparam logic [OFF_W-1:0] OFF_OUT_VAL  = 9'h004;
    localparam logic [OFF_W-1:0] OFF_OUT_EN   = 9'h008;
    localparam logic [OFF_W-1:0] OFF_TRIG_LVL = 9'h00C;
    localparam logic [OFF_W-1:0] OFF_BOTH_EDG = 9'h010;
    localparam logic [OFF_W-1:0] OFF_POLARITY = 9'h014;
    localparam logic [OFF_W-1:0] OFF_IRQ_ENA  = 9'h018;
    localparam logic [OFF_W-1:0] OFF_RAW_STS  = 9'h01C;
    localparam logic [OFF_W-1:0] OFF_MSK_STS  = 9'h020;
    localparam logic [OFF_W-1:0] OFF_STS_CLR  = 9'h024;
    localparam logic [OFF_W-1:0] OFF_PULL_DIR = 9'h034;
    localparam logic [OFF_W-1:0] OFF_PULL_ENA = 9'h038;

    typedef enum logic [1:0] {
        TRIG_EDGE_ONE  = 2'd0,
        TRIG_EDGE_BOTH = 2'd1,
        TRIG_LEVEL     = 2'd2
    } trig_kind_e;

    function automatic trig_kind_e trig_kind(input logic lvl, input logic both);
        if (lvl)       return TRIG_LEVEL;
        else if (both) return TRIG_EDGE_BOTH;
        else           return TRIG_EDGE_ONE;
    endfunction

    function automatic logic trig_event(input trig_kind_e kind, input logic now,
                                        input logic prev, input logic pol);
        logic ev;
        unique case (kind)
            TRIG_LEVEL:     ev = (now == pol);
            TRIG_EDGE_BOTH: ev = now ^ prev;
            TRIG_EDGE_ONE:  ev = pol ? (now & ~prev) : (~now & prev);
            default:        ev = 1'b0;
        endcase
        return ev;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_now,
    input  logic [W-1:0] cfg_lvl,
    input  logic [W-1:0] cfg_both,
    input  logic [W-1:0] cfg_pol,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] raw_sts,
    output logic [W-1:0] level_prev
);
    logic [W-1:0] hit;
    logic [W-1:0] prev_q;
    logic [W-1:0] raw_q;

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign hit[i] = trig_event(trig_kind(cfg_lvl[i], cfg_both[i]),
                                   level_now[i], prev_q[i], cfg_pol[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            raw_q  <= '0;
        end else begin
            prev_q <= level_now;
            raw_q  <= (raw_q & ~clr_bits) | hit;
        end
    end

    assign raw_sts    = raw_q;
    assign level_prev = prev_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = PINS_PER_BANK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [OFF_W-1:0] offset,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     pins,
    output logic [W-1:0]     rd_val,
    output logic [W-1:0]     out_val,
    output logic [W-1:0]     out_en,
    output logic [W-1:0]     pull_ena,
    output logic [W-1:0]     pull_dir,
    output logic [W-1:0]     raw_sts,
    output logic [W-1:0]     irq_ena,
    output logic [W-1:0]     trig_lvl,
    output logic [W-1:0]     level_prev
);
    logic [W-1:0] out_q, oe_q, lvl_q, both_q, pol_q, ena_q, pdir_q, pena_q;
    logic [W-1:0] level_now;
    logic [W-1:0] clr_bits;

    gpio_sync2 #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins),
        .sync_out (level_now)
    );

    assign clr_bits = (wr_sel && offset == OFF_STS_CLR) ? wdata : '0;

    gpio_trig_detect #(.W(W)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_now  (level_now),
        .cfg_lvl    (lvl_q),
        .cfg_both   (both_q),
        .cfg_pol    (pol_q),
        .clr_bits   (clr_bits),
        .raw_sts    (raw_sts),
        .level_prev (level_prev)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            oe_q   <= '0;
            lvl_q  <= '0;
            both_q <= '0;
            pol_q  <= '0;
            ena_q  <= '0;
            pdir_q <= '0;
            pena_q <= '0;
        end else if (wr_sel) begin
            case (offset)
                OFF_OUT_VAL:  out_q  <= wdata;
                OFF_OUT_EN:   oe_q   <= wdata;
                OFF_TRIG_LVL: lvl_q  <= wdata;
                OFF_BOTH_EDG: both_q <= wdata;
                OFF_POLARITY: pol_q  <= wdata;
                OFF_IRQ_ENA:  ena_q  <= wdata;
                OFF_PULL_DIR: pdir_q <= wdata;
                OFF_PULL_ENA: pena_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (offset)
            OFF_LEVEL_IN: rd_val = level_now;
            OFF_OUT_VAL:  rd_val = out_q;
            OFF_OUT_EN:   rd_val = oe_q;
            OFF_TRIG_LVL: rd_val = lvl_q;
            OFF_BOTH_EDG: rd_val = both_q;
            OFF_POLARITY: rd_val = pol_q;
            OFF_IRQ_ENA:  rd_val = ena_q;
            OFF_RAW_STS:  rd_val = raw_sts;
            OFF_MSK_STS:  rd_val = raw_sts & ena_q;
            OFF_PULL_DIR: rd_val = pdir_q;
            OFF_PULL_ENA: rd_val = pena_q;
            default:      rd_val = '0;
        endcase
    end

    assign out_val  = out_q;
    assign out_en   = oe_q;
    assign pull_ena = pena_q;
    assign pull_dir = pdir_q;
    assign irq_ena  = ena_q;
    assign trig_lvl = lvl_q;
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int ADDR_W    = OFF_W + BANK_W,
    parameter int NPINS     = NUM_BANKS * PINS_PER_BANK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pull_en,
    output logic [NPINS-1:0]  pull_up,
    output logic              irq
);
    localparam int PB = PINS_PER_BANK;

    logic [BANK_W-1:0] bank_idx;
    logic [OFF_W-1:0]  offset;
    logic [PB-1:0]     bank_rd [NUM_BANKS];
    logic [NPINS-1:0]  raw_all, ena_all, lvl_all, prev_all;

    assign bank_idx = addr[ADDR_W-1:OFF_W];
    assign offset   = addr[OFF_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = wr_en && (bank_idx == BANK_W'(b));

        gpio_bank_regs #(.W(PB)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_sel     (sel),
            .offset     (offset),
            .wdata      (wdata),
            .pins       (pin_in[b*PB +: PB]),
            .rd_val     (bank_rd[b]),
            .out_val    (pin_out[b*PB +: PB]),
            .out_en     (pin_oe[b*PB +: PB]),
            .pull_ena   (pull_en[b*PB +: PB]),
            .pull_dir   (pull_up[b*PB +: PB]),
            .raw_sts    (raw_all[b*PB +: PB]),
            .irq_ena    (ena_all[b*PB +: PB]),
            .trig_lvl   (lvl_all[b*PB +: PB]),
            .level_prev (prev_all[b*PB +: PB])
        );
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_idx == BANK_W'(b)) rdata = bank_rd[b];
        end
    end

    assign irq = |(raw_all & ena_all);
endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
module gpio_banked_ctrl_chk #(
    parameter int ADDR_W = 10,
    parameter int NPINS  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  pull_en,
    input logic              irq,
    input logic [NPINS-1:0]  raw_all,
    input logic [NPINS-1:0]  ena_all,
    input logic [NPINS-1:0]  lvl_all,
    input logic [NPINS-1:0]  prev_all
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_input_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && addr == ADDR_W'(0)) |-> rdata == $past(pin_in[31:0], 2));

    assert_oe_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $past(wr_en) && $past(addr) == ADDR_W'(9'h008))
        |-> pin_oe[31:0] == $past(wdata));

    assert_pull_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $past(wr_en) && $past(addr) == ADDR_W'(9'h038))
        |-> pull_en[31:0] == $past(wdata));

    assert_edge_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1)
        |-> ((raw_all & ~$past(raw_all) & ~$past(lvl_all) & ~(prev_all ^ $past(prev_all))) == '0));

    assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_all & ena_all) == '0) |-> !irq);
endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk #(.ADDR_W(ADDR_W), .NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .pin_in   (pin_in),
    .pin_oe   (pin_oe),
    .pull_en  (pull_en),
    .irq      (irq),
    .raw_all  (raw_all),
    .ena_all  (ena_all),
    .lvl_all  (lvl_all),
    .prev_all (prev_all)
);

// File: tb/gpio_banked_ctrl_test.sv
module gpio_banked_ctrl_test;
    localparam int NB = 2;
    localparam int NP = NB * 32;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pull_en, pull_up;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_banked_ctrl #(.NUM_BANKS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pull_en(pull_en), .pull_up(pull_up), .irq(irq)
    );

    // behavioural reference state, one bit per pin
    logic [NP-1:0] m_out = '0, m_oe = '0, m_lvl = '0, m_both = '0, m_pol = '0;
    logic [NP-1:0] m_ena = '0, m_pdir = '0, m_pena = '0, m_raw = '0;
    logic [NP-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = '0; m_oe = '0; m_lvl = '0; m_both = '0; m_pol = '0;
            m_ena = '0; m_pdir = '0; m_pena = '0; m_raw = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
        end else begin
            int bank;
            int off;
            logic [NP-1:0] clr;
            logic [NP-1:0] ev;
            bank = int'(addr) / 512;
            off  = int'(addr) % 512;
            clr  = '0;
            if (wr_en && bank < NB && off == 'h24) clr[bank*32 +: 32] = wdata;
            for (int p = 0; p < NP; p++) begin
                if (m_lvl[p])       ev[p] = (m_s2[p] == m_pol[p]);
                else if (m_both[p]) ev[p] = (m_s2[p] != m_prev[p]);
                else if (m_pol[p])  ev[p] = m_s2[p] && !m_prev[p];
                else                ev[p] = !m_s2[p] && m_prev[p];
            end
            m_raw  = (m_raw & ~clr) | ev;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin_in;
            if (wr_en && bank < NB) begin
                case (off)
                    'h04: m_out[bank*32 +: 32]  = wdata;
                    'h08: m_oe[bank*32 +: 32]   = wdata;
                    'h0C: m_lvl[bank*32 +: 32]  = wdata;
                    'h10: m_both[bank*32 +: 32] = wdata;
                    'h14: m_pol[bank*32 +: 32]  = wdata;
                    'h18: m_ena[bank*32 +: 32]  = wdata;
                    'h34: m_pdir[bank*32 +: 32] = wdata;
                    'h38: m_pena[bank*32 +: 32] = wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(input int a);
        int bank = a / 512;
        int off  = a % 512;
        if (bank >= NB) return '0;
        case (off)
            'h00: return m_s2[bank*32 +: 32];
            'h04: return m_out[bank*32 +: 32];
            'h08: return m_oe[bank*32 +: 32];
            'h0C: return m_lvl[bank*32 +: 32];
            'h10: return m_both[bank*32 +: 32];
            'h14: return m_pol[bank*32 +: 32];
            'h18: return m_ena[bank*32 +: 32];
            'h1C: return m_raw[bank*32 +: 32];
            'h20: return m_raw[bank*32 +: 32] & m_ena[bank*32 +: 32];
            'h34: return m_pdir[bank*32 +: 32];
            'h38: return m_pena[bank*32 +: 32];
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every-cycle port comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 pin_out", pin_out, m_out);
            check("R3 pin_oe", pin_oe, m_oe);
            check("R4 pull", {pull_en ^ m_pena, pull_up ^ m_pdir}, '0);
            check("R10 irq", 64'(irq), 64'(|(m_raw & m_ena)));
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        addr = AW'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input string req, output logic [31:0] v);
        addr = AW'(a);
        #1;
        v = rdata;
        check(req, 64'(rdata), 64'(m_read(a)));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3);
        // R11 reset state
        check("R11 reset outputs", {pin_out | pin_oe, 63'(0), irq}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int o = 0; o < 'h40; o += 4) begin
            rd(o, "R11 reset read", v);
            check("R11 reset value", 64'(v), 64'(0));
        end

        // R3 / R1 output drive in both banks
        wr('h004, 32'hA5A5_0F0F);
        wr('h008, 32'hFFFF_0000);
        wr('h204, 32'h1234_5678);
        wr('h208, 32'h0000_00FF);
        check("R1 bank1 out", 64'(pin_out[63:32]), 64'h1234_5678);
        check("R3 oe bank0", 64'(pin_oe[31:0]), 64'hFFFF_0000);

        // R4 pulls
        wr('h034, 32'h0000_F0F0);
        wr('h038, 32'h0000_FF00);
        check("R4 pull_up", 64'(pull_up[15:0]), 64'hF0F0);
        check("R4 pull_en", 64'(pull_en[15:0]), 64'hFF00);

        // R11 writes to unused / read-only offsets
        wr('h02C, 32'hFFFF_FFFF);
        wr('h01C, 32'hFFFF_FFFF);
        wr('h000, 32'hFFFF_FFFF);
        rd('h02C, "R11 unused reads 0", v);
        check("R11 unused", 64'(v), 64'(0));
        rd('h01C, "R11 raw read-only", v);
        check("R11 raw untouched", 64'(v), 64'(0));

        // R2 synchronised input, R1 bank placement of pin 40
        pin_in = 64'h0000_0100_0000_00C0;
        @(negedge clk);
        rd('h000, "R2 one edge", v);
        check("R2 not yet visible", 64'(v), 64'(0));
        @(negedge clk);
        rd('h000, "R2 two edges", v);
        check("R2 visible", 64'(v), 64'h0000_00C0);
        rd('h200, "R1 bank1 input", v);
        check("R1 pin40 bit8", 64'(v), 64'h0000_0100);
        pin_in = '0;  // falling edges latch with default config
        idle(4);
        wr('h024, 32'hFFFF_FFFF);
        wr('h224, 32'hFFFF_FFFF);
        rd('h01C, "R9 clear all", v);
        check("R9 cleared", 64'(v), 64'(0));

        // R6 rising edge on pin 3, mask on
        wr('h014, 32'h0000_0008);
        wr('h018, 32'h0000_0008);
        pin_in[3] = 1'b1;
        idle(5);
        rd('h01C, "R6 rise", v);
        check("R6 rise latched", 64'(v[3]), 64'(1));
        check("R10 irq from bank0", 64'(irq), 64'(1));
        pin_in[3] = 1'b0;
        idle(5);
        rd('h01C, "R6 sticky", v);
        check("R6 sticky after fall", 64'(v[3]), 64'(1));
        wr('h024, 32'h0000_0000);
        rd('h01C, "R9 zero write", v);
        check("R9 zero no effect", 64'(v[3]), 64'(1));
        wr('h024, 32'h0000_0008);
        rd('h01C, "R9 one write", v);
        check("R9 bit cleared", 64'(v[3]), 64'(0));
        check("R10 irq drops", 64'(irq), 64'(0));

        // R6 falling edge on pin 4 (polarity 0)
        pin_in[4] = 1'b1;
        idle(5);
        rd('h01C, "R6 no rise on falling pin", v);
        check("R6 rise ignored", 64'(v[4]), 64'(0));
        pin_in[4] = 1'b0;
        idle(5);
        rd('h01C, "R6 fall", v);
        check("R6 fall latched", 64'(v[4]), 64'(1));

        // R7 both edges on pin 5 with polarity 1
        wr('h014, 32'h0000_0028);
        wr('h010, 32'h0000_0020);
        pin_in[5] = 1'b1;
        idle(5);
        rd('h01C, "R7 rise", v);
        check("R7 rise latched", 64'(v[5]), 64'(1));
        wr('h024, 32'h0000_0020);
        pin_in[5] = 1'b0;
        idle(5);
        rd('h01C, "R7 fall", v);
        check("R7 fall latched", 64'(v[5]), 64'(1));

        // R5 level high on pin 6, R8 masked view
        wr('h024, 32'hFFFF_FFFF);
        wr('h00C, 32'h0000_0040);
        wr('h014, 32'h0000_0068);
        pin_in[6] = 1'b1;
        idle(5);
        wr('h024, 32'h0000_0040);
        rd('h01C, "R5 reassert", v);
        check("R5 still set after clear", 64'(v[6]), 64'(1));
        rd('h020, "R8 masked", v);
        check("R8 unmasked pin hidden", 64'(v[6]), 64'(0));
        check("R8 irq low while masked", 64'(irq), 64'(0));
        pin_in[6] = 1'b0;
        idle(5);
        wr('h024, 32'h0000_0040);
        rd('h01C, "R5 level gone", v);
        check("R5 clears when inactive", 64'(v[6]), 64'(0));

        // R10 bank1 pin 40 rising edge raises irq
        wr('h214, 32'h0000_0100);
        wr('h218, 32'h0000_0100);
        pin_in[40] = 1'b1;
        idle(5);
        rd('h220, "R10 bank1 masked", v);
        check("R10 bank1 status", 64'(v[8]), 64'(1));
        check("R10 irq from bank1", 64'(irq), 64'(1));
        wr('h224, 32'h0000_0100);
        check("R10 irq cleared", 64'(irq), 64'(0));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule